// File: doc/BRIEF.md
# Character LCD Strobe Sequencer

This block turns one character-LCD access into the short series of SPI words that an SPI-to-parallel latch needs in order to clock that access into the display. A requester presents an 8-bit value and a flag that selects between display data and an instruction. Each 16-bit word places the value on the LCD data lines. It also carries the register-select level, a read/write level that is always write, and an enable level. Three such words go out in a row. Only the enable level differs between them: high, then low, then high. The LCD therefore sees a falling enable edge while the rest of its bus is steady.

The words go to an SPI master over a valid/ready handshake. The SPI master then pulses a completion input once the word has left the shift register. The sequencer never hands over the next word before that pulse. After the last word, a programmable count of idle cycles can follow, which gives slow LCD instructions time to execute. While a sequence runs the block reports busy and refuses new requests. A one-cycle done pulse marks the return to idle.

Top module: `lcd_strobe_seq`

## Requirements
- R1: After reset the block is idle: busy=0, done=0, spi_valid=0 and req_ready=1.
- R2: Every accepted request produces exactly three words. Bit 8 (enable) is 1 in the first word, 0 in the second and 1 in the third.
- R3: In all three words, bits 7:0 equal the requested value, bit 10 is 1 for data and 0 for an instruction, bit 9 (read/write) is 0 and bits 15:11 are 0. The value and kind are captured at acceptance, so later changes on the request inputs have no effect.
- R4: While spi_valid=1 and spi_ready=0, spi_valid stays 1 and spi_word stays unchanged.
- R5: After a word is handed over (spi_valid and spi_ready both 1), spi_valid stays 0 until spi_done has been seen for that word.
- R6: A request is accepted only when req_ready=1, and req_ready equals the inverse of busy. A request raised while busy is ignored.
- R7: busy rises in the cycle after acceptance. It falls in the same cycle that done is high for exactly one cycle, at the end of the sequence.
- R8: With gap_cycles=G captured at acceptance, busy stays high for G cycles after the cycle that takes the third spi_done. With G=0, busy falls in the next cycle.
- R9: A clear-screen instruction (value 0x01, instruction) produces the words 0x0101, 0x0001, 0x0101.
- R10: An spi_done pulse while no word is in flight (idle, or a word presented but not yet taken) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe from the requester |
| req_ready | output | 1 | High when a request can be accepted |
| req_is_data | input | 1 | 1 = display data, 0 = instruction |
| req_value | input | 8 | Byte for the LCD data lines |
| gap_cycles | input | GAP_W (12) | Idle cycles after the last word |
| spi_valid | output | 1 | Word offered to the SPI master |
| spi_ready | input | 1 | SPI master takes the word |
| spi_word | output | 16 | Word to shift out |
| spi_done | input | 1 | One-cycle pulse: the taken word has finished |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The assertions assume that spi_done is a single-cycle pulse and that the SPI master raises it at most once for each word it took. They also assume the requester treats req_ready as the only acceptance indication. The random stimulus respects this: completion comes only after a hand-off, with a random delay, and the SPI side stalls for a random number of cycles. Stray completion pulses are injected deliberately only where R10 says they must be ignored, namely while idle or while a word waits to be taken. Requests raised while busy, and changing request values after acceptance, test that captured state cannot be disturbed.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
    localparam int LCD_DATA_W  = 8;
    localparam int LCD_WORD_W  = 16;
    localparam int EN_POS      = 8;
    localparam int RW_POS      = 9;
    localparam int RS_POS      = 10;
    localparam int NUM_WORDS   = 3;
    localparam int PHASE_W     = $clog2(NUM_WORDS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_GAP
    } seq_state_e;
endpackage

// File: rtl/lcd_word_fmt.sv
module lcd_word_fmt
    import lcd_seq_pkg::*;
#(
    parameter int DATA_W = LCD_DATA_W,
    parameter int WORD_W = LCD_WORD_W
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic               is_data,
    input  logic [DATA_W-1:0]  value,
    output logic [WORD_W-1:0]  word
);
    localparam int LOW_W = RS_POS + 1;

    logic [LOW_W-1:0] low_part;

    always_comb begin
        low_part               = '0;
        low_part[DATA_W-1:0]   = value;
        // enable high on even phases, low on odd: gives high-low-high
        low_part[EN_POS]       = ~phase[0];
        low_part[RW_POS]       = 1'b0;
        low_part[RS_POS]       = is_data;
    end

    generate
        if (WORD_W > LOW_W) begin : g_pad
            assign word = {{(WORD_W-LOW_W){1'b0}}, low_part};
        end else begin : g_exact
            assign word = low_part[WORD_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/lcd_gap_timer.sv
module lcd_gap_timer #(
    parameter int GAP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             expire
);
    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == GAP_W'(1));
endmodule

// File: rtl/lcd_strobe_seq.sv
module lcd_strobe_seq
    import lcd_seq_pkg::*;
#(
    parameter int DATA_W = LCD_DATA_W,
    parameter int WORD_W = LCD_WORD_W,
    parameter int GAP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_data,
    input  logic [DATA_W-1:0] req_value,
    input  logic [GAP_W-1:0]  gap_cycles,
    output logic              spi_valid,
    input  logic              spi_ready,
    output logic [WORD_W-1:0] spi_word,
    input  logic              spi_done,
    output logic              busy,
    output logic              done
);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_WORDS - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [PHASE_W-1:0] phase;
        logic               is_data;
        logic [DATA_W-1:0]  value;
        logic [GAP_W-1:0]   gap;
        logic               done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  tmr_load;
    logic  tmr_expire;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        tmr_load    = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.st      = ST_SEND;
                    ctrl_d.phase   = '0;
                    ctrl_d.is_data = req_is_data;
                    ctrl_d.value   = req_value;
                    ctrl_d.gap     = gap_cycles;
                end
            end
            ST_SEND: begin
                if (spi_ready) begin
                    ctrl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (spi_done) begin
                    if (ctrl_q.phase == LAST_PHASE) begin
                        if (ctrl_q.gap == '0) begin
                            ctrl_d.st   = ST_IDLE;
                            ctrl_d.done = 1'b1;
                        end else begin
                            ctrl_d.st = ST_GAP;
                            tmr_load  = 1'b1;
                        end
                    end else begin
                        ctrl_d.phase = ctrl_q.phase + 1'b1;
                        ctrl_d.st    = ST_SEND;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expire) begin
                    ctrl_d.st   = ST_IDLE;
                    ctrl_d.done = 1'b1;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, phase: '0, is_data: 1'b0,
                        value: '0, gap: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    lcd_gap_timer #(.GAP_W(GAP_W)) gap_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (ctrl_q.gap),
        .expire   (tmr_expire)
    );

    lcd_word_fmt #(.DATA_W(DATA_W), .WORD_W(WORD_W)) fmt_i (
        .phase   (ctrl_q.phase),
        .is_data (ctrl_q.is_data),
        .value   (ctrl_q.value),
        .word    (spi_word)
    );

    assign req_ready = (ctrl_q.st == ST_IDLE);
    assign busy      = (ctrl_q.st != ST_IDLE);
    assign spi_valid = (ctrl_q.st == ST_SEND);
    assign done      = ctrl_q.done;
endmodule

// File: rtl/lcd_strobe_seq_chk.sv
module lcd_strobe_seq_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              spi_valid,
    input logic              spi_ready,
    input logic [WORD_W-1:0] spi_word,
    input logic              spi_done,
    input logic              busy,
    input logic              done
);
    // R4: offered word held until taken
    p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_valid && !spi_ready |=> spi_valid && $stable(spi_word));

    // R5: no new word right after a hand-off
    p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_valid && spi_ready |=> !spi_valid);

    // R3: read/write and upper bits are zero whenever a word is offered
    p_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_valid |-> (spi_word[9] == 1'b0) && (spi_word[WORD_W-1:11] == '0));

    // R7: acceptance makes the block busy
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy);

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done coincides with the end of busy
    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));

    // R6: no acceptance while busy
    p_refuse_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R10: completion while idle changes nothing
    p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && spi_done && !req_valid |=> !busy && !spi_valid);
endmodule

bind lcd_strobe_seq lcd_strobe_seq_chk #(.WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .spi_valid (spi_valid),
    .spi_ready (spi_ready),
    .spi_word  (spi_word),
    .spi_done  (spi_done),
    .busy      (busy),
    .done      (done)
);

// File: tb/lcd_strobe_seq_tb_top.sv
module lcd_strobe_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_W      = 12;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_is_data = 1'b0;
    logic [7:0]        req_value = '0;
    logic [GAP_W-1:0]  gap_cycles = '0;
    logic              spi_valid;
    logic              spi_ready = 1'b0;
    logic [15:0]       spi_word;
    logic              spi_done = 1'b0;
    logic              busy;
    logic              done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_strobe_seq #(.GAP_W(GAP_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_data(req_is_data), .req_value(req_value),
        .gap_cycles(gap_cycles),
        .spi_valid(spi_valid), .spi_ready(spi_ready), .spi_word(spi_word),
        .spi_done(spi_done), .busy(busy), .done(done)
    );

    function automatic logic [15:0] exp_word(input logic d, input logic [7:0] v, input int k);
        logic [15:0] w;
        w = 16'h0000;
        w[7:0] = v;
        w[8]   = (k != 1);
        w[10]  = d;
        return w;
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic run_seq(input logic d, input logic [7:0] v, input int gap,
                           input int hold_max, input int tag9);
        int waits;
        logic [15:0] e;
        @(negedge clk);
        chk(req_ready == 1'b1, "R6 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_is_data = d; req_value = v; gap_cycles = GAP_W'(gap);
        @(negedge clk);
        req_valid = 1'b0;
        req_value = ~v; req_is_data = ~d; gap_cycles = GAP_W'($urandom % 7);
        chk(busy == 1'b1, "R7 busy after accept", busy, 1);
        for (int k = 0; k < 3; k++) begin
            waits = 0;
            while (!spi_valid && waits < 50) begin @(negedge clk); waits++; end
            e = exp_word(d, v, k);
            if (tag9 != 0)
                chk(spi_word == e, "R9 clear-screen word", spi_word, e);
            else
                chk(spi_word == e, "R2/R3 word content", spi_word, e);
            for (int h = 0; h < int'($urandom % hold_max); h++) begin
                req_valid = 1'b1;                  // R6: ignored while busy
                spi_done  = ($urandom % 2) == 0;   // R10: ignored before hand-off
                @(negedge clk);
                req_valid = 1'b0; spi_done = 1'b0;
                chk(spi_valid && spi_word == e, "R4 held word", spi_word, e);
                chk(req_ready == 1'b0, "R6 refused while busy", req_ready, 0);
            end
            spi_ready = 1'b1;
            @(negedge clk);
            spi_ready = 1'b0;
            chk(spi_valid == 1'b0, "R5 no word before done", spi_valid, 0);
            for (int l = 0; l < int'($urandom % 4); l++) begin
                @(negedge clk);
                chk(spi_valid == 1'b0, "R5 waiting for done", spi_valid, 0);
            end
            spi_done = 1'b1;
            @(negedge clk);
            spi_done = 1'b0;
        end
        waits = 0;
        while (busy && waits < 5000) begin
            chk(done == 1'b0, "R7 no done while busy", done, 0);
            @(negedge clk); waits++;
        end
        chk(waits == gap, "R8 gap length", waits, gap);
        chk(done == 1'b1, "R7 done as busy falls", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
    endtask

    initial begin
        void'($urandom(32'd5813));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && spi_valid == 1'b0 && req_ready == 1'b1,
            "R1 reset state", {busy, done, spi_valid, req_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && req_ready == 1'b1, "R1 after release", {busy, req_ready}, 2'b01);

        // R10: stray completion while idle
        spi_done = 1'b1;
        @(negedge clk);
        spi_done = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && spi_valid == 1'b0, "R10 idle done ignored", {busy, spi_valid}, 0);

        run_seq(1'b0, 8'h01, 0, 3, 1);   // R9 clear screen
        run_seq(1'b1, 8'hFF, 1, 4, 0);
        run_seq(1'b0, 8'h00, 5, 2, 0);
        run_seq(1'b1, 8'hA5, 0, 1, 0);
        for (int t = 0; t < 30; t++) begin
            run_seq(1'($urandom), 8'($urandom), int'($urandom % 6), 1 + int'($urandom % 5), 0);
            repeat (int'($urandom % 3)) @(negedge clk);
        end
        finish_run();
    end
endmodule